// File: doc/BRIEF.md
# Pad Pull Resistor Programming Sequencer

This block drives the pull-up and pull-down enables of a row of pads (54 by default). Software does not write a pull setting per pin directly. It first writes a shared 2-bit pull mode. After a setup delay it raises strobe bits in one of the per-bank strobe registers. It then clears those bits again. On the cycle a strobe bit is cleared, the pin under that bit copies the shared mode into its own pull state. The pull state of each pin is held only in the pad logic. No bus read returns it: the strobe registers read back only the strobe bits themselves.

A counter runs from every mode write and from reset. It raises `mode_stable` once the setup delay (150 clocks by default) has elapsed. A strobe bit that is raised before that point is still honoured. Such a strobe sets the sticky `setup_viol` flag, so software that hurries the sequence can be caught.

Top module: `pad_pull_seq`

## Requirements
- R1: The mode register sits at byte address 0x94. Writes keep only data bits [1:0], and reads return those two bits with bits [31:2] as zero.
- R2: The strobe register at 0x98 covers pins 0..31 in bits 0..31. The one at 0x9C covers pins 32..53 in bits 0..21. Each reads back the strobe bits last written, and bits with no pin behind them read as zero.
- R3: When a write clears a strobe bit that was set, that pin takes the current mode in the same clock edge. Mode 0 means no pull, 1 means pull-down (`pull_dn_en` high) and 2 means pull-up (`pull_up_en` high).
- R4: If the mode is 3 when a strobe bit is cleared, the pin keeps its previous pull state.
- R5: A pin's pull state changes only when its strobe bit falls. It does not change on a mode write or on a strobe bit rising. It never appears in any read data.
- R6: `mode_stable` goes low at the clock edge that accepts a mode write. It rises at the 150th clock edge after that one. After reset it rises at the 150th clock edge after reset is released.
- R7: A write that raises any strobe bit at a clock edge where `mode_stable` is low sets `setup_viol`. The flag stays set until the next mode write or reset.
- R8: After reset every pin has no pull. Both register types read zero, and `mode_stable` and `setup_viol` are low.
- R9: `pull_up_en` and `pull_dn_en` are never high for the same pin.
- R10: Writes to any other address change nothing, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pull_up_en | output | 54 | Per-pin pull-up enable |
| pull_dn_en | output | 54 | Per-pin pull-down enable |
| mode_stable | output | 1 | Setup delay since last mode write has elapsed |
| setup_viol | output | 1 | Sticky flag: strobe raised before setup elapsed |

## Verification
The assertions check on every cycle that the two enables of a pin are never high together. They also check that a pin's state holds whenever its strobe is not falling, that the mode and strobe registers hold when they are not written, and that a mode write drops `mode_stable`. They also check that the violation flag stays set between mode writes. Only the bench scenarios can show the rest: that the right mode lands in the right pins across both banks, that mode 3 preserves state, that the setup window ends on the exact cycle, and that unused strobe bits and unmapped addresses read zero. A behavioural model supplies the expected values for these.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;
   typedef enum logic [1:0] {
      PULL_NONE = 2'd0,
      PULL_DOWN = 2'd1,
      PULL_UP   = 2'd2,
      PULL_KEEP = 2'd3
   } pull_mode_e;
endpackage

// File: rtl/pull_mode_ctrl.sv
module pull_mode_ctrl
   import pad_pull_pkg::*;
#(
   parameter int SETUP_CYCLES = 150
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [1:0] mode_in,
   input  logic       strobe_rise,
   output pull_mode_e mode_q,
   output logic       mode_stable,
   output logic       setup_viol
);
   localparam int CNT_W = $clog2(SETUP_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETUP_CYCLES);

   logic [CNT_W-1:0] settle_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= PULL_NONE;
         settle_cnt <= '0;
         setup_viol <= 1'b0;
      end else if (mode_wr) begin
         mode_q     <= pull_mode_e'(mode_in);
         settle_cnt <= '0;
         setup_viol <= 1'b0;
      end else begin
         if (settle_cnt != CNT_MAX) settle_cnt <= settle_cnt + 1'b1;
         if (strobe_rise && !mode_stable) setup_viol <= 1'b1;
      end
   end

   assign mode_stable = (settle_cnt == CNT_MAX);

   // R1
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode_q));
   // R6
   stable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !mode_stable);
   // R7
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_viol && !mode_wr) |=> setup_viol);
endmodule

// File: rtl/pull_strobe_bank.sv
module pull_strobe_bank #(
   parameter int WIDTH = 32,
   parameter int LIVE  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [LIVE-1:0]  wdata,
   output logic [WIDTH-1:0] strobe_q,
   output logic [LIVE-1:0]  fall,
   output logic             rise_any
);
   logic [LIVE-1:0] live_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  live_q <= '0;
      else if (wr) live_q <= wdata;
   end

   generate
      if (LIVE == WIDTH) begin : g_full
         assign strobe_q = live_q;
      end else begin : g_part
         assign strobe_q = {{(WIDTH-LIVE){1'b0}}, live_q};
      end
   endgenerate

   assign fall     = {LIVE{wr}} & live_q & ~wdata;
   assign rise_any = wr & (|(~live_q & wdata));

   // R2
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(live_q));
endmodule

// File: rtl/pull_pad_cell.sv
module pull_pad_cell
   import pad_pull_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       latch,
   input  pull_mode_e mode,
   output logic       pu,
   output logic       pd
);
   pull_mode_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= PULL_NONE;
      else if (latch && mode != PULL_KEEP) state_q <= mode;
   end

   assign pu = (state_q == PULL_UP);
   assign pd = (state_q == PULL_DOWN);

   // R5
   pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable({pu, pd}));
   // R9
   pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pu && pd));
endmodule

// File: rtl/pad_pull_seq.sv
module pad_pull_seq
   import pad_pull_pkg::*;
#(
   parameter int NUM_PINS     = 54,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int SETUP_CYCLES = 150,
   parameter int MODE_ADDR    = 'h94,
   parameter int STROBE_ADDR  = 'h98
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] pull_up_en,
   output logic [NUM_PINS-1:0] pull_dn_en,
   output logic                mode_stable,
   output logic                setup_viol
);
   localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int BANK_STEP = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 8");
      end
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("NUM_PINS must be positive");
      end
      if (SETUP_CYCLES < 1) begin : g_bad_setup
         $error("SETUP_CYCLES must be positive");
      end
   endgenerate

   pull_mode_e                    mode_q;
   logic                          mode_wr;
   logic [NUM_BANKS*DATA_W-1:0]   strobe_all;
   logic [NUM_PINS-1:0]           fall_all;
   logic [NUM_BANKS-1:0]          rise_vec;

   assign mode_wr = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));

   pull_mode_ctrl #(.SETUP_CYCLES(SETUP_CYCLES)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (mode_wr),
      .mode_in     (bus_wdata[1:0]),
      .strobe_rise (|rise_vec),
      .mode_q      (mode_q),
      .mode_stable (mode_stable),
      .setup_viol  (setup_viol)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int REST = NUM_PINS - b * DATA_W;
      localparam int LIVE = (REST > DATA_W) ? DATA_W : REST;
      logic hit;
      assign hit = bus_wr && (bus_addr == ADDR_W'(STROBE_ADDR + BANK_STEP * b));

      pull_strobe_bank #(.WIDTH(DATA_W), .LIVE(LIVE)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (hit),
         .wdata    (bus_wdata[LIVE-1:0]),
         .strobe_q (strobe_all[b*DATA_W +: DATA_W]),
         .fall     (fall_all[b*DATA_W +: LIVE]),
         .rise_any (rise_vec[b])
      );
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      pull_pad_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .latch (fall_all[p]),
         .mode  (mode_q),
         .pu    (pull_up_en[p]),
         .pd    (pull_dn_en[p])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(MODE_ADDR)) bus_rdata[1:0] = mode_q;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(STROBE_ADDR + BANK_STEP * b))
            bus_rdata = strobe_all[b*DATA_W +: DATA_W];
      end
   end

   // R9
   pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en & pull_dn_en) == '0);
endmodule

// File: tb/tb_pad_pull_seq.sv
module tb_pad_pull_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 54;
   localparam int SETUP = 150;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pull_up_en, pull_dn_en;
   logic        mode_stable, setup_viol;

   int checks = 0;
   int errors = 0;
   bit running = 1'b0;

   pad_pull_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
      .mode_stable(mode_stable), .setup_viol(setup_viol)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   logic [1:0]  m_mode;
   logic [31:0] m_strb [2];
   logic [1:0]  m_pin [NP];
   int          m_cnt;
   bit          m_viol;

   always @(posedge clk) begin
      bit stab;
      if (!rst_n) begin
         m_mode = 0; m_strb[0] = 0; m_strb[1] = 0; m_cnt = 0; m_viol = 0;
         for (int p = 0; p < NP; p++) m_pin[p] = 0;
      end else begin
         stab = (m_cnt >= SETUP);
         if (bus_wr && bus_addr == 8'h94) begin
            m_mode = bus_wdata[1:0]; m_cnt = 0; m_viol = 0;
         end else begin
            if (m_cnt < SETUP) m_cnt++;
            for (int b = 0; b < 2; b++) begin
               if (bus_wr && bus_addr == 8'h98 + 8'(4*b)) begin
                  for (int i = 0; i < 32; i++) begin
                     if (b*32 + i < NP) begin
                        if (m_strb[b][i] && !bus_wdata[i] && m_mode != 2'd3)
                           m_pin[b*32+i] = m_mode;
                        if (!m_strb[b][i] && bus_wdata[i] && !stab) m_viol = 1;
                        m_strb[b][i] = bus_wdata[i];
                     end
                  end
               end
            end
         end
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      if (a == 8'h94) return {30'b0, m_mode};
      if (a == 8'h98) return m_strb[0];
      if (a == 8'h9C) return m_strb[1];
      return 32'h0;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (running && rst_n) begin
         logic [NP-1:0] eu, ed;
         for (int p = 0; p < NP; p++) begin
            eu[p] = (m_pin[p] == 2'd2);
            ed[p] = (m_pin[p] == 2'd1);
         end
         chk("R3 R4 R5 pull_up_en", 64'(pull_up_en), 64'(eu));
         chk("R3 R4 R5 pull_dn_en", 64'(pull_dn_en), 64'(ed));
         chk("R9 exclusive", 64'(pull_up_en & pull_dn_en), 64'h0);
         chk("R6 mode_stable", 64'(mode_stable), 64'(m_cnt >= SETUP));
         chk("R7 setup_viol", 64'(setup_viol), 64'(m_viol));
         if (bus_addr == 8'h94)      chk("R1 read mode", 64'(bus_rdata), 64'(m_read(bus_addr)));
         else if (bus_addr == 8'h98 || bus_addr == 8'h9C)
                                     chk("R2 R5 read strobe", 64'(bus_rdata), 64'(m_read(bus_addr)));
         else                        chk("R10 read other", 64'(bus_rdata), 64'(m_read(bus_addr)));
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic idle(int n, logic [7:0] a);
      bus_addr = a;
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog R8 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 pu after reset", 64'(pull_up_en), 64'h0);
      chk("R8 pd after reset", 64'(pull_dn_en), 64'h0);
      chk("R8 stable after reset", 64'(mode_stable), 64'h0);
      chk("R8 viol after reset", 64'(setup_viol), 64'h0);
      #1 bus_addr = 8'h98; #1;
      chk("R8 strobe reads zero", 64'(bus_rdata), 64'h0);
      idle(155, 8'h94);

      // R3 pull-up on bank 0 pins 0, 5, 31
      wr(8'h94, 32'h0000_0002);
      chk("R6 stable low after write", 64'(mode_stable), 64'h0);
      idle(152, 8'h98);
      wr(8'h98, 32'h8000_0021);
      idle(152, 8'h98);
      wr(8'h98, 32'h0);
      chk("R3 pull-up pins", 64'(pull_up_en), 64'h0000_0000_8000_0021);
      chk("R5 strobe read hides state", 64'(bus_rdata), 64'h0);

      // R1 upper bits dropped, pull-down on all of bank 1
      wr(8'h94, 32'hFFFF_FFFD);
      idle(3, 8'h94);
      chk("R1 mode low bits", 64'(bus_rdata), 64'h1);
      idle(152, 8'h9C);
      wr(8'h9C, 32'hFFFF_FFFF);
      #1;
      chk("R2 unused bits zero", 64'(bus_rdata), 64'h003F_FFFF);
      idle(152, 8'h9C);
      wr(8'h9C, 32'h0);
      chk("R3 pull-down bank 1", 64'(pull_dn_en), 64'h003F_FFFF_0000_0000);

      // R4 mode 3 keeps state
      wr(8'h94, 32'h3);
      idle(152, 8'h98);
      wr(8'h98, 32'h0000_0001);
      idle(152, 8'h98);
      wr(8'h98, 32'h0);
      chk("R4 keep pin 0", 64'(pull_up_en[0]), 64'h1);

      // R7 early strobe sets the flag, still honoured
      wr(8'h94, 32'h0);
      wr(8'h98, 32'h0000_0020);
      chk("R7 viol set", 64'(setup_viol), 64'h1);
      wr(8'h98, 32'h0);
      idle(200, 8'h98);
      chk("R7 viol sticky", 64'(setup_viol), 64'h1);
      chk("R3 early strobe honoured", 64'(pull_up_en[5]), 64'h0);
      wr(8'h94, 32'h1);
      chk("R7 viol cleared", 64'(setup_viol), 64'h0);

      // R5 rising strobe alone does nothing, R9 up then down on pin 31
      idle(152, 8'h98);
      wr(8'h98, 32'h8000_0000);
      chk("R5 rise no change", 64'(pull_up_en[31]), 64'h1);
      wr(8'h98, 32'h0);
      chk("R9 pin 31 now down", 64'({pull_up_en[31], pull_dn_en[31]}), 64'h1);

      // R10 unmapped writes
      wr(8'hA0, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      idle(2, 8'hA0);
      chk("R10 unmapped read", 64'(bus_rdata), 64'h0);
      idle(4, 8'h94);

      running = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule